// File: doc/BRIEF.md
# Exception and Interrupt Entry Sequencer

This block sits at the instruction boundary of a CPU pipeline. When the pipeline raises its accept strobe, the block looks at two things: a pending synchronous exception code and a pending external interrupt (with its priority level and event code). It decides which one, if either, is taken. It then computes, in one registered update, the architectural state for entering the handler. That state is the return address, the saved status word, the saved stack pointer, the event code registers, the new status word and the handler address.

Exceptions always win over interrupts. While the status word's block bit is set, an exception turns into a reset, except for one code that remains allowed. Under the same block bit an interrupt is simply not taken. Each class of event has its own handler address:

- TLB misses go to the vector base plus 0x400.
- Other exceptions go to the vector base plus 0x100.
- Interrupts go to the vector base plus 0x600.
- Reset goes to a fixed address.

The return address is corrected when the event hits a branch delay slot, and when the event is the trap-always instruction.

Top module: `exc_entry_seq`

## Requirements
- R1: When the accept strobe is high and both an exception and an interrupt are pending, the exception is taken: the exception event output gets the exception code and the interrupt event output keeps its previous value.
- R2: An exception is handled as reset in two cases: its code is 0x000, or the block bit (status bit 28) is set and its code is anything other than 0x1E0. Handling as reset means the exception event output becomes 0x000, the new PC is 0xA0000000, and new status bits 7:4 are all ones.
- R3: With the block bit set, exception code 0x1E0 is handled as an ordinary exception: its code is recorded and the new PC is the vector base plus 0x100.
- R4: With the block bit set and only an interrupt pending, no entry happens. The entry pulse stays low and every state output keeps its value.
- R5: An interrupt is taken only when its level is strictly greater than status bits 7:4. When it is taken, the interrupt event output gets the interrupt code, the new PC is the vector base plus 0x600, and the exception event output is unchanged. A level equal to or below the mask causes no entry.
- R6: On every entry, three saves are made: the saved status gets the incoming status, the saved stack pointer gets the incoming register-15 value, and the new status is the incoming status with bits 28 (block), 29 (register bank) and 30 (privileged) set. All other status bits pass through unchanged, apart from the reset mask in R2.
- R7: The return address is the incoming PC, or the incoming PC minus 2 when the delay-slot flag is high. This applies to exceptions and interrupts alike.
- R8: Exception codes 0x040 and 0x060 go to the vector base plus 0x400. Every other non-reset exception goes to the vector base plus 0x100.
- R9: For exception code 0x160 (trap-always, block bit clear), the return address is advanced by 2 over the R7 value.
- R10: State changes only on a clock edge where the accept strobe is high and an event is taken. The entry pulse is high for exactly the cycle after such an edge. Without the strobe, pending events have no effect.
- R11: After reset every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| take_i | input | 1 | Accept strobe at an instruction boundary |
| exc_valid_i | input | 1 | An exception is pending |
| exc_code_i | input | 12 | Pending exception code |
| irq_valid_i | input | 1 | An interrupt is pending |
| irq_level_i | input | 4 | Pending interrupt priority level |
| irq_code_i | input | 12 | Pending interrupt event code |
| sr_i | input | 32 | Current status word |
| vbr_i | input | 32 | Vector base |
| pc_i | input | 32 | PC of the instruction at the boundary |
| gr15_i | input | 32 | Current register 15 (stack pointer) |
| dslot_i | input | 1 | Instruction is in a branch delay slot |
| entry_o | output | 1 | One-cycle pulse after an event is taken |
| sr_o | output | 32 | New status word |
| pc_o | output | 32 | Handler address |
| ssr_o | output | 32 | Saved status word |
| spc_o | output | 32 | Saved return address |
| sgr_o | output | 32 | Saved stack pointer |
| expevt_o | output | 12 | Last exception event code |
| intevt_o | output | 12 | Last interrupt event code |

## Verification
Every output is due exactly one clock after the edge that samples the accept strobe, because the only register on the path is the output register itself. The bench drives a boundary's inputs just after a falling edge. Its behavioural model predicts the state that the next rising edge must load. All outputs are compared at the following falling edge, and the next boundary is driven in the same instant, so each clock carries one stimulus and one comparison. Cycles without the strobe are compared the same way, to show the outputs hold.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;

  localparam int CODE_W = 12;

  // status word bit positions that the handler entry manipulates
  localparam int BLK_BIT   = 28;
  localparam int RBANK_BIT = 29;
  localparam int PRIV_BIT  = 30;
  localparam int MASK_LSB  = 4;

  // event codes with special treatment
  localparam logic [CODE_W-1:0] CODE_RESET  = 12'h000;
  localparam logic [CODE_W-1:0] CODE_UNMASK = 12'h1E0;
  localparam logic [CODE_W-1:0] CODE_TRAP   = 12'h160;

  localparam int N_TLB_CODES = 2;
  localparam logic [CODE_W-1:0] TLB_CODES [N_TLB_CODES] = '{12'h040, 12'h060};

  // handler addresses
  localparam logic [31:0] RESET_PC = 32'hA000_0000;
  localparam logic [31:0] OFS_GEN  = 32'h0000_0100;
  localparam logic [31:0] OFS_TLB  = 32'h0000_0400;
  localparam logic [31:0] OFS_IRQ  = 32'h0000_0600;

  // instruction parcel size used for return-address fixups
  localparam logic [31:0] PARCEL = 32'd2;

  typedef enum logic [1:0] {
    EV_NONE  = 2'd0,
    EV_EXC   = 2'd1,
    EV_RESET = 2'd2,
    EV_IRQ   = 2'd3
  } ev_kind_e;

endpackage

// File: rtl/exc_seq_arbiter.sv
module exc_seq_arbiter
  import exc_seq_pkg::*;
#(
  parameter int LVL_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_i,
  input  logic              exc_valid_i,
  input  logic [CODE_W-1:0] exc_code_i,
  input  logic              irq_valid_i,
  input  logic [LVL_W-1:0]  irq_level_i,
  input  logic              sr_blk_i,
  input  logic [LVL_W-1:0]  sr_imask_i,
  output ev_kind_e          kind_o,
  output logic [CODE_W-1:0] code_o
);

  logic exc_forced_reset;
  logic irq_passes;

  always_comb begin
    exc_forced_reset = sr_blk_i && (exc_code_i != CODE_UNMASK);
    irq_passes       = irq_valid_i && !sr_blk_i && (irq_level_i > sr_imask_i);
  end

  always_comb begin
    kind_o = EV_NONE;
    code_o = exc_code_i;
    if (take_i) begin
      if (exc_valid_i) begin
        if (exc_forced_reset || (exc_code_i == CODE_RESET)) begin
          kind_o = EV_RESET;
          code_o = CODE_RESET;
        end else begin
          kind_o = EV_EXC;
        end
      end else if (irq_passes) begin
        kind_o = EV_IRQ;
      end
    end
  end

  // R4
  blk_irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && !exc_valid_i && sr_blk_i) |-> (kind_o == EV_NONE));

  // R10
  no_take_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !take_i |-> (kind_o == EV_NONE));

endmodule

// File: rtl/exc_seq_vector.sv
module exc_seq_vector
  import exc_seq_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  ev_kind_e          kind_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [XLEN-1:0]   vbr_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic              dslot_i,
  output logic [XLEN-1:0]   new_pc_o,
  output logic [XLEN-1:0]   ret_pc_o
);

  logic [N_TLB_CODES-1:0] tlb_hit;
  logic                   is_tlb;
  logic                   is_trap;
  logic [XLEN-1:0]        ret_base;

  for (genvar g = 0; g < N_TLB_CODES; g++) begin : g_tlb
    assign tlb_hit[g] = (code_i == TLB_CODES[g]);
  end

  always_comb begin
    is_tlb   = |tlb_hit;
    is_trap  = (kind_i == EV_EXC) && (code_i == CODE_TRAP);
    ret_base = dslot_i ? (pc_i - XLEN'(PARCEL)) : pc_i;
    ret_pc_o = is_trap ? (ret_base + XLEN'(PARCEL)) : ret_base;
  end

  always_comb begin
    unique case (kind_i)
      EV_RESET: new_pc_o = XLEN'(RESET_PC);
      EV_IRQ:   new_pc_o = vbr_i + XLEN'(OFS_IRQ);
      EV_EXC:   new_pc_o = vbr_i + (is_tlb ? XLEN'(OFS_TLB) : XLEN'(OFS_GEN));
      default:  new_pc_o = pc_i;
    endcase
  end

endmodule

// File: rtl/exc_seq_regs.sv
module exc_seq_regs
  import exc_seq_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int LVL_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ev_kind_e          kind_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [CODE_W-1:0] irq_code_i,
  input  logic [XLEN-1:0]   sr_i,
  input  logic [XLEN-1:0]   gr15_i,
  input  logic [XLEN-1:0]   new_pc_i,
  input  logic [XLEN-1:0]   ret_pc_i,
  output logic              entry_o,
  output logic [XLEN-1:0]   sr_o,
  output logic [XLEN-1:0]   pc_o,
  output logic [XLEN-1:0]   ssr_o,
  output logic [XLEN-1:0]   spc_o,
  output logic [XLEN-1:0]   sgr_o,
  output logic [CODE_W-1:0] expevt_o,
  output logic [CODE_W-1:0] intevt_o
);

  logic            upd_ctx;
  logic            upd_exp;
  logic            upd_int;
  logic [XLEN-1:0] sr_nx;

  always_comb begin
    upd_ctx = (kind_i != EV_NONE);
    upd_exp = (kind_i == EV_EXC) || (kind_i == EV_RESET);
    upd_int = (kind_i == EV_IRQ);
    sr_nx            = sr_i;
    sr_nx[BLK_BIT]   = 1'b1;
    sr_nx[RBANK_BIT] = 1'b1;
    sr_nx[PRIV_BIT]  = 1'b1;
    if (kind_i == EV_RESET) begin
      sr_nx[MASK_LSB +: LVL_W] = '1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      entry_o  <= 1'b0;
      sr_o     <= '0;
      pc_o     <= '0;
      ssr_o    <= '0;
      spc_o    <= '0;
      sgr_o    <= '0;
      expevt_o <= '0;
      intevt_o <= '0;
    end else begin
      entry_o <= upd_ctx;
      if (upd_ctx) begin
        ssr_o <= sr_i;
        spc_o <= ret_pc_i;
        sgr_o <= gr15_i;
        sr_o  <= sr_nx;
        pc_o  <= new_pc_i;
      end
      if (upd_exp) begin
        expevt_o <= code_i;
      end
      if (upd_int) begin
        intevt_o <= irq_code_i;
      end
    end
  end

  // R6
  ctx_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    entry_o |-> (sr_o[BLK_BIT] && sr_o[RBANK_BIT] && sr_o[PRIV_BIT]));

  // R10
  hold_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_i == EV_NONE) |=> (!entry_o && $stable(pc_o) && $stable(spc_o)
                             && $stable(sr_o) && $stable(expevt_o) && $stable(intevt_o)));

  // R2
  reset_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_i == EV_RESET) |=> ((pc_o == XLEN'(RESET_PC)) && (&sr_o[MASK_LSB +: LVL_W])
                              && (expevt_o == CODE_RESET)));

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_seq_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int LVL_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_i,
  input  logic              exc_valid_i,
  input  logic [CODE_W-1:0] exc_code_i,
  input  logic              irq_valid_i,
  input  logic [LVL_W-1:0]  irq_level_i,
  input  logic [CODE_W-1:0] irq_code_i,
  input  logic [XLEN-1:0]   sr_i,
  input  logic [XLEN-1:0]   vbr_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [XLEN-1:0]   gr15_i,
  input  logic              dslot_i,
  output logic              entry_o,
  output logic [XLEN-1:0]   sr_o,
  output logic [XLEN-1:0]   pc_o,
  output logic [XLEN-1:0]   ssr_o,
  output logic [XLEN-1:0]   spc_o,
  output logic [XLEN-1:0]   sgr_o,
  output logic [CODE_W-1:0] expevt_o,
  output logic [CODE_W-1:0] intevt_o
);

  ev_kind_e          ev_kind;
  logic [CODE_W-1:0] ev_code;
  logic [XLEN-1:0]   new_pc;
  logic [XLEN-1:0]   ret_pc;

  exc_seq_arbiter #(.LVL_W(LVL_W)) arb_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .take_i      (take_i),
    .exc_valid_i (exc_valid_i),
    .exc_code_i  (exc_code_i),
    .irq_valid_i (irq_valid_i),
    .irq_level_i (irq_level_i),
    .sr_blk_i    (sr_i[BLK_BIT]),
    .sr_imask_i  (sr_i[MASK_LSB +: LVL_W]),
    .kind_o      (ev_kind),
    .code_o      (ev_code)
  );

  exc_seq_vector #(.XLEN(XLEN)) vec_i (
    .kind_i   (ev_kind),
    .code_i   (ev_code),
    .vbr_i    (vbr_i),
    .pc_i     (pc_i),
    .dslot_i  (dslot_i),
    .new_pc_o (new_pc),
    .ret_pc_o (ret_pc)
  );

  exc_seq_regs #(.XLEN(XLEN), .LVL_W(LVL_W)) regs_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .kind_i     (ev_kind),
    .code_i     (ev_code),
    .irq_code_i (irq_code_i),
    .sr_i       (sr_i),
    .gr15_i     (gr15_i),
    .new_pc_i   (new_pc),
    .ret_pc_i   (ret_pc),
    .entry_o    (entry_o),
    .sr_o       (sr_o),
    .pc_o       (pc_o),
    .ssr_o      (ssr_o),
    .spc_o      (spc_o),
    .sgr_o      (sgr_o),
    .expevt_o   (expevt_o),
    .intevt_o   (intevt_o)
  );

  // R1
  exc_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && exc_valid_i) |=> (entry_o && $stable(intevt_o)));

  // R5
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && !exc_valid_i && (irq_level_i <= sr_i[MASK_LSB +: LVL_W])) |=> !entry_o);

  // R6
  save_ctx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && exc_valid_i) |=> ((ssr_o == $past(sr_i)) && (sgr_o == $past(gr15_i))));

  // R7
  dslot_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && exc_valid_i && dslot_i && (exc_code_i != CODE_TRAP))
      |=> (spc_o == $past(pc_i) - XLEN'(PARCEL)));

  // R3
  unmask_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && exc_valid_i && (exc_code_i == CODE_UNMASK)) |=> (expevt_o == CODE_UNMASK));

endmodule

// File: tb/exc_entry_seq_tb.sv
module exc_entry_seq_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        take_i;
  logic        exc_valid_i;
  logic [11:0] exc_code_i;
  logic        irq_valid_i;
  logic [3:0]  irq_level_i;
  logic [11:0] irq_code_i;
  logic [31:0] sr_i, vbr_i, pc_i, gr15_i;
  logic        dslot_i;
  logic        entry_o;
  logic [31:0] sr_o, pc_o, ssr_o, spc_o, sgr_o;
  logic [11:0] expevt_o, intevt_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // expected state (behavioural model)
  bit          e_entry;
  logic [31:0] e_sr, e_pc, e_ssr, e_spc, e_sgr;
  logic [11:0] e_expevt, e_intevt;

  always #10 clk = ~clk;

  exc_entry_seq dut_i (
    .clk(clk), .rst_n(rst_n), .take_i(take_i),
    .exc_valid_i(exc_valid_i), .exc_code_i(exc_code_i),
    .irq_valid_i(irq_valid_i), .irq_level_i(irq_level_i), .irq_code_i(irq_code_i),
    .sr_i(sr_i), .vbr_i(vbr_i), .pc_i(pc_i), .gr15_i(gr15_i), .dslot_i(dslot_i),
    .entry_o(entry_o), .sr_o(sr_o), .pc_o(pc_o), .ssr_o(ssr_o), .spc_o(spc_o),
    .sgr_o(sgr_o), .expevt_o(expevt_o), .intevt_o(intevt_o)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic compare_all(input string req);
    chk(req, "entry",  {31'd0, entry_o}, {31'd0, e_entry});
    chk(req, "sr",     sr_o,  e_sr);
    chk(req, "pc",     pc_o,  e_pc);
    chk(req, "ssr",    ssr_o, e_ssr);
    chk(req, "spc",    spc_o, e_spc);
    chk(req, "sgr",    sgr_o, e_sgr);
    chk(req, "expevt", {20'd0, expevt_o}, {20'd0, e_expevt});
    chk(req, "intevt", {20'd0, intevt_o}, {20'd0, e_intevt});
  endtask

  task automatic predict(input bit tk, input bit ev, input logic [11:0] ec,
                         input bit iv, input logic [3:0] il, input logic [11:0] ic,
                         input logic [31:0] s, input logic [31:0] v,
                         input logic [31:0] p, input logic [31:0] g, input bit ds);
    bit          go_exc = 0;
    bit          go_irq = 0;
    logic [11:0] code = ec;
    e_entry = 0;
    if (tk) begin
      if (ev) begin
        go_exc = 1;
        if (s[28] && ec != 12'h1E0) code = 12'h000;
      end else if (iv && !s[28] && il > s[7:4]) begin
        go_irq = 1;
      end
    end
    if (go_exc || go_irq) begin
      e_entry = 1;
      e_ssr = s;
      e_sgr = g;
      e_spc = ds ? p - 32'd2 : p;
      e_sr  = s | 32'h7000_0000;
      if (go_irq) begin
        e_intevt = ic;
        e_pc     = v + 32'h600;
      end else begin
        e_expevt = code;
        if (code == 12'h000) begin
          e_sr[7:4] = 4'hF;
          e_pc = 32'hA000_0000;
        end else if (code == 12'h040 || code == 12'h060) begin
          e_pc = v + 32'h400;
        end else begin
          e_pc = v + 32'h100;
          if (code == 12'h160) e_spc = e_spc + 32'd2;
        end
      end
    end
  endtask

  // called at a falling edge; drives, then compares at the next falling edge
  task automatic step(input string req, input bit tk, input bit ev, input logic [11:0] ec,
                      input bit iv, input logic [3:0] il, input logic [11:0] ic,
                      input logic [31:0] s, input logic [31:0] v,
                      input logic [31:0] p, input logic [31:0] g, input bit ds);
    take_i = tk; exc_valid_i = ev; exc_code_i = ec;
    irq_valid_i = iv; irq_level_i = il; irq_code_i = ic;
    sr_i = s; vbr_i = v; pc_i = p; gr15_i = g; dslot_i = ds;
    predict(tk, ev, ec, iv, il, ic, s, v, p, g, ds);
    @(negedge clk);
    compare_all(req);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] VB;
    VB = 32'h8C00_0000;
    rst_n = 1'b0;
    step_init();
    e_entry = 0; e_sr = 0; e_pc = 0; e_ssr = 0; e_spc = 0; e_sgr = 0;
    e_expevt = 0; e_intevt = 0;
    repeat (3) @(negedge clk);
    compare_all("R11");
    rst_n = 1'b1;
    @(negedge clk);
    compare_all("R11");

    // no strobe: pending events ignored
    step("R10", 0, 1, 12'h0E0, 1, 4'hF, 12'h320, 32'h0000_0000, VB, 32'h8C00_1000, 32'h1111, 0);
    step("R10", 0, 0, 12'h000, 1, 4'hF, 12'h320, 32'h0000_0000, VB, 32'h8C00_1004, 32'h1111, 0);
    // plain exception
    step("R8",  1, 0, 12'h000, 0, 4'h0, 12'h000, 32'h0000_00F3, VB, 32'h8C00_1000, 32'h7FF0, 0);
    step("R8",  1, 1, 12'h0E0, 0, 4'h0, 12'h000, 32'h0000_0013, VB, 32'h8C00_2000, 32'h7FE0, 0);
    step("R10", 0, 0, 12'h000, 0, 4'h0, 12'h000, 32'h0000_0000, VB, 32'h0,         32'h0,    0);
    step("R8",  1, 1, 12'h040, 0, 4'h0, 12'h000, 32'h0000_0001, VB, 32'h0040_0010, 32'h7FD0, 0);
    step("R8",  1, 1, 12'h060, 0, 4'h0, 12'h000, 32'h0000_0002, VB, 32'h0040_0020, 32'h7FC0, 0);
    step("R8",  1, 1, 12'h0A0, 0, 4'h0, 12'h000, 32'h0000_0002, VB, 32'h0040_0030, 32'h7FB0, 0);
    // priority
    step("R1",  1, 1, 12'h180, 1, 4'hF, 12'h3C0, 32'h0000_0000, VB, 32'h0040_0040, 32'h7FA0, 0);
    // interrupts
    step("R5",  1, 0, 12'h000, 1, 4'h5, 12'h240, 32'h0000_0030, VB, 32'h0040_0050, 32'h7F90, 0);
    step("R5",  1, 0, 12'h000, 1, 4'h3, 12'h260, 32'h0000_0030, VB, 32'h0040_0060, 32'h7F80, 0);
    step("R5",  1, 0, 12'h000, 1, 4'hF, 12'h200, 32'h0000_00E0, VB, 32'h0040_0070, 32'h7F70, 0);
    step("R5",  1, 0, 12'h000, 1, 4'h0, 12'h220, 32'h0000_0000, VB, 32'h0040_0080, 32'h7F60, 0);
    // block bit
    step("R2",  1, 1, 12'h0A0, 0, 4'h0, 12'h000, 32'h1000_0050, VB, 32'h0040_0090, 32'h7F50, 0);
    step("R3",  1, 1, 12'h1E0, 0, 4'h0, 12'h000, 32'h1000_0050, VB, 32'h0040_00A0, 32'h7F40, 0);
    step("R4",  1, 0, 12'h000, 1, 4'hF, 12'h2E0, 32'h1000_0000, VB, 32'h0040_00B0, 32'h7F30, 0);
    step("R2",  1, 1, 12'h160, 0, 4'h0, 12'h000, 32'h1000_0000, VB, 32'h0040_00C0, 32'h7F20, 1);
    step("R2",  1, 1, 12'h000, 1, 4'hF, 12'h2A0, 32'h0000_0020, VB, 32'h0040_00D0, 32'h7F10, 0);
    // delay slot and trap
    step("R7",  1, 1, 12'h180, 0, 4'h0, 12'h000, 32'h0000_0000, VB, 32'h0040_1002, 32'h7F00, 1);
    step("R7",  1, 0, 12'h000, 1, 4'h9, 12'h320, 32'h0000_0040, VB, 32'h0040_2006, 32'h7EF0, 1);
    step("R9",  1, 1, 12'h160, 0, 4'h0, 12'h000, 32'h0000_0000, VB, 32'h0040_3000, 32'h7EE0, 0);
    step("R9",  1, 1, 12'h160, 0, 4'h0, 12'h000, 32'h0000_0000, VB, 32'h0040_4004, 32'h7ED0, 1);
    // status pass-through
    step("R6",  1, 1, 12'h0C0, 0, 4'h0, 12'h000, 32'h8FFF_FF0F, 32'h0, 32'hFFFF_FFFE, 32'hDEAD_BEEF, 0);

    // mixed stimulus
    for (int i = 0; i < 60; i++) begin
      logic [11:0] codes [8];
      codes = '{12'h000, 12'h040, 12'h060, 12'h0A0, 12'h0E0, 12'h160, 12'h1E0, 12'h180};
      step("R6", ($urandom_range(0, 3) != 0), $urandom_range(0, 1) == 1,
           codes[$urandom_range(0, 7)], $urandom_range(0, 1) == 1,
           4'($urandom_range(0, 15)), 12'($urandom_range(0, 4095)),
           $urandom & 32'h9FFF_FFFF | (($urandom_range(0, 3) == 0) ? 32'h1000_0000 : 32'h0),
           $urandom, $urandom, $urandom, $urandom_range(0, 1) == 1);
    end

    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic step_init();
    take_i = 0; exc_valid_i = 0; exc_code_i = '0; irq_valid_i = 0;
    irq_level_i = '0; irq_code_i = '0; sr_i = '0; vbr_i = '0; pc_i = '0;
    gr15_i = '0; dslot_i = 0;
  endtask

endmodule